// File: doc/BRIEF.md
# Octant-Coarsening Sharer Vector Unit

This block keeps the sharer field of one directory entry for a machine of up to 512 nodes. The nodes form eight octants of 64. While every sharer sits in one octant, the field is exact: a 64-bit vector with one bit per node, tagged with the octant number. Once sharers come from two or more octants, the field becomes coarse. In coarse form each of the 64 bits stands for a group of eight consecutive nodes. Four operations act on the field: clear, set to a single sharer, add a sharer, and expand. Expand turns the field into a stream of unicast invalidation targets, one node ID per cycle, and leaves out the requesting node.

Entries may arrive in a 16-bit stored form meant for small machines. The block widens such an entry on entry, runs the operation on the wide form, and narrows the result before handing it back. Wide entries bypass both conversions. An update result comes out one cycle after the operation is accepted. An expansion holds the unit busy until it reports completion together with the number of targets it emitted.

Top module: `shv_unit`

## Requirements
- R1: After a synchronous reset, busy, ent_valid, tgt_valid and exp_done are all low.
- R2: The wide entry layout is bit 67 = coarse flag, bits 66:64 = octant, bits 63:0 = vector. A clear operation (op 0) returns the entry as all zeros, which is exact mode, octant 0, no sharers.
- R3: A set operation (op 1) returns an exact-mode entry whose octant is node_id[8:6] and whose vector has only bit node_id[5:0] set.
- R4: An add operation (op 2) on an exact-mode entry sets bit node_id[5:0] and stays exact. This holds when the vector is empty, in which case the octant becomes node_id[8:6]. It also holds when the octant already equals node_id[8:6].
- R5: An add on a non-empty exact-mode entry of another octant returns a coarse entry with octant 0. Each previously set bit i maps to group bit octant*8 + i/8, and group bit node_id[8:3] is set as well.
- R6: An add on a coarse entry sets group bit node_id[8:3], and the entry stays coarse.
- R7: Clear, set and add are accepted only while busy is low. The result appears on ent_out with a one-cycle ent_valid pulse in the cycle after acceptance.
- R8: With narrow high, only ent_in[15:0] is used. It is read as an exact vector of nodes 0 to 15 in octant 0. The result is returned in ent_out[15:0], with ent_out[67:16] zero. Narrow entries are expanded the same way.
- R9: Expand (op 3) emits one target per cycle in ascending node ID order, starting in the second cycle after acceptance. In exact mode bit i stands for node octant*64 + i. In coarse mode bit g stands for nodes 8g to 8g+7.
- R10: Expand never emits the requester (node_id at acceptance) and never emits an ID of NODES or more.
- R11: exp_done pulses in the cycle after the last target, with exp_count equal to the number of targets emitted. An empty field gives exp_done in the second cycle after acceptance with a count of 0.
- R12: An operation presented while busy is high is ignored. It produces no ent_valid and does not change the running expansion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op | input | 2 | 0 clear, 1 set, 2 add, 3 expand |
| node_id | input | 9 | Sharer to set or add; requester for expand |
| narrow | input | 1 | Entry is in the 16-bit stored form |
| ent_in | input | 68 | Current stored entry |
| busy | output | 1 | Expansion in progress |
| ent_valid | output | 1 | Update result valid |
| ent_out | output | 68 | Updated stored entry |
| tgt_valid | output | 1 | Invalidation target valid |
| tgt_id | output | 9 | Invalidation target node ID |
| exp_done | output | 1 | Expansion finished |
| exp_count | output | $clog2(NODES+1) | Targets emitted by the last expansion |

## Verification
The bench builds the unit with NODES set to 300, so that octant 4 (nodes 256 to 319) is cut part way. An exact-mode bit at node 306 and coarse group 37 (nodes 296 to 303) therefore reach past the node limit, and the bench can see that the IDs above 299 are dropped while 296 to 299 still come out. The requester sits inside a set group to show that it is skipped. Requests sent during an expansion and narrow-form entries are exercised as well.

// File: rtl/shv_pkg.sv
package shv_pkg;
    localparam int VEC_W    = 64;
    localparam int NARROW_W = 16;
    localparam int OCT_W    = 3;
    localparam int LOW_W    = 6;
    localparam int GRP_SH   = 3;
    localparam int NODE_W   = OCT_W + LOW_W;
    localparam int GRP_W    = NODE_W - GRP_SH;
    localparam int ENT_W    = 1 + OCT_W + VEC_W;

    typedef enum logic [1:0] {
        OP_CLEAR  = 2'd0,
        OP_SET    = 2'd1,
        OP_ADD    = 2'd2,
        OP_EXPAND = 2'd3
    } shv_op_e;

    typedef struct packed {
        logic               coarse;
        logic [OCT_W-1:0]   oct;
        logic [VEC_W-1:0]   vec;
    } shv_ent_t;

    // Stored word to working form
    function automatic shv_ent_t widen(logic [ENT_W-1:0] raw, logic nar);
        shv_ent_t e;
        if (nar) begin
            e        = '0;
            e.vec    = {{(VEC_W-NARROW_W){1'b0}}, raw[NARROW_W-1:0]};
        end else begin
            e = shv_ent_t'(raw);
        end
        return e;
    endfunction

    // Working form back to stored word
    function automatic logic [ENT_W-1:0] shrink(shv_ent_t e, logic nar);
        if (nar)
            return {{(ENT_W-NARROW_W){1'b0}}, e.vec[NARROW_W-1:0]};
        return ENT_W'(e);
    endfunction

    // Fold an exact vector into per-group bits
    function automatic logic [VEC_W-1:0] coarsen(shv_ent_t e);
        logic [VEC_W-1:0] g;
        g = '0;
        for (int i = 0; i < VEC_W; i++) begin
            if (e.vec[i])
                g[{e.oct, i[LOW_W-1:GRP_SH]}] = 1'b1;
        end
        return g;
    endfunction
endpackage

// File: rtl/shv_update.sv
module shv_update
    import shv_pkg::*;
(
    input  shv_op_e              op,
    input  logic [NODE_W-1:0]    node_id,
    input  shv_ent_t             cur,
    output shv_ent_t             nxt
);
    logic [GRP_W-1:0] grp;
    logic [OCT_W-1:0] oct_n;
    logic [LOW_W-1:0] low;

    assign grp   = node_id[NODE_W-1:GRP_SH];
    assign oct_n = node_id[NODE_W-1:LOW_W];
    assign low   = node_id[LOW_W-1:0];

    always_comb begin
        nxt = cur;
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_SET: begin
                nxt          = '0;
                nxt.oct      = oct_n;
                nxt.vec[low] = 1'b1;
            end
            OP_ADD: begin
                if (cur.coarse) begin
                    nxt.vec[grp] = 1'b1;
                end else if (cur.vec == '0 || cur.oct == oct_n) begin
                    nxt.oct      = oct_n;
                    nxt.vec[low] = 1'b1;
                end else begin
                    nxt.coarse   = 1'b1;
                    nxt.oct      = '0;
                    nxt.vec      = coarsen(cur);
                    nxt.vec[grp] = 1'b1;
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/shv_expand.sv
module shv_expand
    import shv_pkg::*;
#(
    parameter int NODES = 512,
    localparam int CNT_W = $clog2(NODES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  shv_ent_t             ent,
    input  logic [NODE_W-1:0]    req,
    output logic                 busy,
    output logic                 tgt_valid,
    output logic [NODE_W-1:0]    tgt_id,
    output logic                 exp_done,
    output logic [CNT_W-1:0]     exp_count
);
    logic [NODES-1:0]  fill;
    logic [NODES-1:0]  pend;
    logic [NODE_W-1:0] first;
    logic [NODE_W-1:0] req_q;

    // Map the field onto per-node candidates
    always_comb begin
        logic [NODE_W-1:0] nn;
        logic hit;
        for (int n = 0; n < NODES; n++) begin
            nn  = NODE_W'(n);
            hit = ent.coarse ? ent.vec[nn[NODE_W-1:GRP_SH]]
                             : (ent.oct == nn[NODE_W-1:LOW_W]) && ent.vec[nn[LOW_W-1:0]];
            fill[n] = hit && (nn != req);
        end
    end

    always_comb begin
        first = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend[i]) first = NODE_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            tgt_valid <= 1'b0;
            tgt_id    <= '0;
            exp_done  <= 1'b0;
            exp_count <= '0;
            pend      <= '0;
            req_q     <= '0;
        end else begin
            exp_done <= 1'b0;
            if (!busy) begin
                tgt_valid <= 1'b0;
                if (start) begin
                    busy      <= 1'b1;
                    pend      <= fill;
                    req_q     <= req;
                    exp_count <= '0;
                end
            end else if (pend != '0) begin
                tgt_valid   <= 1'b1;
                tgt_id      <= first;
                pend[first] <= 1'b0;
                exp_count   <= exp_count + 1'b1;
            end else begin
                tgt_valid <= 1'b0;
                exp_done  <= 1'b1;
                busy      <= 1'b0;
            end
        end
    end

    // R10
    no_self_target_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> tgt_id != req_q);
    // R10
    id_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> int'(tgt_id) < NODES);
    // R9
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && $past(tgt_valid)) |-> tgt_id > $past(tgt_id));
    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        exp_done |-> (!tgt_valid && !busy));
endmodule

// File: rtl/shv_unit.sv
module shv_unit
    import shv_pkg::*;
#(
    parameter int NODES = 512,
    localparam int CNT_W = $clog2(NODES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [1:0]           op,
    input  logic [NODE_W-1:0]    node_id,
    input  logic                 narrow,
    input  logic [ENT_W-1:0]     ent_in,
    output logic                 busy,
    output logic                 ent_valid,
    output logic [ENT_W-1:0]     ent_out,
    output logic                 tgt_valid,
    output logic [NODE_W-1:0]    tgt_id,
    output logic                 exp_done,
    output logic [CNT_W-1:0]     exp_count
);
    shv_op_e  op_e;
    shv_ent_t cur;
    shv_ent_t nxt;
    logic     accept;
    logic     start_exp;

    assign op_e      = shv_op_e'(op);
    assign cur       = widen(ent_in, narrow);
    assign accept    = op_valid && !busy;
    assign start_exp = accept && (op_e == OP_EXPAND);

    shv_update u_update (
        .op      (op_e),
        .node_id (node_id),
        .cur     (cur),
        .nxt     (nxt)
    );

    shv_expand #(.NODES(NODES)) u_expand (
        .clk       (clk),
        .rst       (rst),
        .start     (start_exp),
        .ent       (cur),
        .req       (node_id),
        .busy      (busy),
        .tgt_valid (tgt_valid),
        .tgt_id    (tgt_id),
        .exp_done  (exp_done),
        .exp_count (exp_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= 1'b0;
            ent_out   <= '0;
        end else begin
            ent_valid <= accept && (op_e != OP_EXPAND);
            if (accept && op_e != OP_EXPAND)
                ent_out <= shrink(nxt, narrow);
        end
    end

    // R3
    set_single_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && $past(op_valid && !busy && op == 2'd1 && !narrow))
        |-> ($countones(ent_out[VEC_W-1:0]) == 1 && !ent_out[ENT_W-1]));
    // R6
    coarse_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && $past(op_valid && !busy && op == 2'd2 && !narrow && ent_in[ENT_W-1]))
        |-> ent_out[ENT_W-1]);
    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !ent_valid);
endmodule

// File: tb/shv_unit_test.sv
module shv_unit_test;
    localparam int NODES = 300;
    localparam int CW    = $clog2(NODES + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [8:0]  node_id = '0;
    logic        narrow = 1'b0;
    logic [67:0] ent_in = '0;
    logic        busy, ent_valid, tgt_valid, exp_done;
    logic [67:0] ent_out;
    logic [8:0]  tgt_id;
    logic [CW-1:0] exp_count;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    shv_unit #(.NODES(NODES)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .node_id(node_id),
        .narrow(narrow), .ent_in(ent_in), .busy(busy), .ent_valid(ent_valid),
        .ent_out(ent_out), .tgt_valid(tgt_valid), .tgt_id(tgt_id),
        .exp_done(exp_done), .exp_count(exp_count)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [67:0] mk(bit c, int oct, logic [63:0] v);
        return {c, 3'(oct), v};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [67:0] act, logic [67:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Expected target list derived from the field encoding rules
    function automatic void model(bit nar, logic [67:0] e, int req, ref int q[$]);
        bit c; int oct; logic [63:0] v; bit hit;
        q.delete();
        if (nar) begin c = 0; oct = 0; v = {48'b0, e[15:0]}; end
        else begin c = e[67]; oct = int'(e[66:64]); v = e[63:0]; end
        for (int n = 0; n < NODES; n++) begin
            hit = c ? v[n / 8] : ((n / 64) == oct && v[n % 64]);
            if (hit && n != req) q.push_back(n);
        end
    endfunction

    task automatic do_upd(bit nar, logic [67:0] e, int o, int node, logic [67:0] expv, string req);
        @(negedge clk);
        op_valid = 1'b1; op = 2'(o); node_id = 9'(node); narrow = nar; ent_in = e;
        @(negedge clk);
        op_valid = 1'b0;
        chk(ent_valid == 1'b1, "R7", "ent_valid pulse", 68'(ent_valid), 68'd1);
        chk(ent_out == expv, req, "ent_out", ent_out, expv);
        @(negedge clk);
        chk(ent_valid == 1'b0, "R7", "ent_valid single cycle", 68'(ent_valid), 68'd0);
    endtask

    task automatic do_exp(bit nar, logic [67:0] e, int req, bit inject, string tag);
        int expq[$];
        int got[$];
        bit done = 0;
        bit ev_seen = 0;
        int cnt = -1;
        model(nar, e, req, expq);
        @(negedge clk);
        op_valid = 1'b1; op = 2'd3; node_id = 9'(req); narrow = nar; ent_in = e;
        @(negedge clk);
        op_valid = 1'b0;
        chk(busy == 1'b1, "R11", {tag, " busy after accept"}, 68'(busy), 68'd1);
        if (inject) begin
            op_valid = 1'b1; op = 2'd1; node_id = 9'd5; ent_in = '0;
        end
        for (int k = 0; k < 700 && !done; k++) begin
            @(negedge clk);
            op_valid = 1'b0;
            if (ent_valid) ev_seen = 1;
            if (tgt_valid) got.push_back(int'(tgt_id));
            if (exp_done) begin done = 1; cnt = int'(exp_count); end
        end
        chk(done, "R11", {tag, " done seen"}, 68'(done), 68'd1);
        chk(got.size() == expq.size(), "R10", {tag, " target total"},
            68'(got.size()), 68'(expq.size()));
        for (int i = 0; i < got.size() && i < expq.size(); i++)
            chk(got[i] == expq[i], "R9", {tag, " target id"}, 68'(got[i]), 68'(expq[i]));
        chk(cnt == expq.size(), "R11", {tag, " exp_count"}, 68'(cnt), 68'(expq.size()));
        if (inject)
            chk(!ev_seen, "R12", {tag, " op while busy ignored"}, 68'(ev_seen), 68'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy && !ent_valid && !tgt_valid && !exp_done, "R1", "reset outputs",
            {64'b0, busy, ent_valid, tgt_valid, exp_done}, 68'd0);

        // R2
        do_upd(0, {4'hF, 64'hDEAD_BEEF_0123_4567}, 0, 77, 68'd0, "R2");
        // R3: node 421 = octant 6, bit 37
        do_upd(0, mk(1, 2, 64'hFF), 1, 421, mk(0, 6, 64'd1 << 37), "R3");
        // R4: same octant
        do_upd(0, mk(0, 6, 64'd1 << 37), 2, 386, mk(0, 6, (64'd1 << 37) | 64'd4), "R4");
        // R4: empty exact vector adopts the new octant
        do_upd(0, mk(0, 5, 64'd0), 2, 10, mk(0, 0, 64'd1 << 10), "R4");
        // R5: octant 6 bits 2,37 -> groups 48,52; node 10 -> group 1
        do_upd(0, mk(0, 6, (64'd1 << 37) | 64'd4), 2, 10,
               mk(1, 0, (64'd1 << 48) | (64'd1 << 52) | 64'd2), "R5");
        // R6: node 200 -> group 25
        do_upd(0, mk(1, 0, 64'd2), 2, 200, mk(1, 0, (64'd1 << 25) | 64'd2), "R6");
        // R8: narrow add and clear
        do_upd(1, {52'hFFFFF_FFFF_FFFF, 16'h0005}, 2, 9, 68'h0205, "R8");
        do_upd(1, {52'hFFFFF_FFFF_FFFF, 16'h1234}, 0, 3, 68'h0, "R8");

        // R9/R10: exact octant 4, bit 50 is node 306 beyond NODES, 257 is requester
        do_exp(0, mk(0, 4, (64'd1 << 50) | (64'd1 << 40) | 64'd3), 257, 0, "R9 exact");
        // R9/R10: coarse groups 2 and 37, requester 18 inside group 2
        do_exp(0, mk(1, 0, (64'd1 << 37) | (64'd1 << 2)), 18, 0, "R10 coarse");
        // R11: empty field
        do_exp(0, mk(0, 3, 64'd0), 0, 0, "R11 empty");
        // R12: set request issued while expanding
        do_exp(0, mk(1, 0, 64'h8000_0000_0000_0011), 7, 1, "R12 busy");
        // R8: narrow expansion
        do_exp(1, {52'hFFFFF_FFFF_FFFF, 16'h8003}, 0, 0, "R8 narrow");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule